// File: doc/BRIEF.md
# Octal-Field Opcode Decoder

This block takes one 8-bit opcode and splits it into three octal fields: a 2-bit group `[7:6]`, a 3-bit upper field `[5:3]` and a 3-bit lower field `[2:0]`. From these fields it works out what kind of instruction the byte is. The result is presented as a one-hot class vector, together with the values an execution sequencer needs:

- the destination register select and the source register select;
- the register-pair select;
- the ALU operation;
- whether an 8-bit operand slot refers to memory addressed through HL;
- how many immediate bytes follow the opcode;
- the base number of clock states.

The decoder is purely combinational, so its outputs follow the opcode within the same cycle. A fetch sequencer latches the opcode and reads `imm_bytes` to know how many operand bytes to fetch. The execution sequencer then branches on the single asserted class bit and uses the select fields as they are. The 3-bit register code is B=0, C=1, D=2, E=3, H=4, L=5, memory-via-HL=6, A=7. Code 6 marks a memory operand: it raises `mem_ref` and lengthens the state count.

Top module: `octal_opcode_decoder`

## Requirements
- R1: Exactly one bit of `op_class` is high for every opcode. The bit positions are: 0 idle, 1 move, 2 load-immediate, 3 increment, 4 decrement, 5 ALU-on-register, 6 ALU-immediate, 7 pair-load, 8 pair-add, 9 pair-increment, 10 pair-decrement, 11 push, 12 pop, 13 halt.
- R2: An opcode with group 1 (octal 1DS), other than 0x76, is class move. It gives `dst_reg`=D and `src_reg`=S. It takes 5 states, or 7 states with `mem_ref`=1 when D or S equals 6.
- R3: Opcode 0x76 is class halt and takes 7 states. It has `mem_ref`=0, `dst_reg`=0, `src_reg`=0 and `imm_bytes`=0.
- R4: An opcode 0D6 (octal) is class load-immediate. It gives `dst_reg`=D and `imm_bytes`=1. It takes 7 states, or 10 states with `mem_ref`=1 when D=6.
- R5: An opcode 0D4 is class increment and 0D5 is class decrement. Both give `dst_reg`=D. They take 5 states, or 10 states with `mem_ref`=1 when D=6.
- R6: An opcode 2OS is class ALU-on-register. It gives `src_reg`=S and `alu_op`=O, where 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare. It takes 4 states, or 7 states with `mem_ref`=1 when S=6.
- R7: An opcode 3O6 is class ALU-immediate. It gives `alu_op`=O (same encoding as R6), `imm_bytes`=1 and 7 states.
- R8: In group 0, with PP=bits[5:4], the pair instructions decode as follows. `pair_sel`=PP in every case, where 0 BC, 1 DE, 2 HL, 3 SP.
  - 00PP0001 is pair-load, with `imm_bytes`=2 and 10 states.
  - 00PP1001 is pair-add, with 10 states.
  - 00PP0011 is pair-increment, with 5 states.
  - 00PP1011 is pair-decrement, with 5 states.
- R9: 11PP0101 is push (11 states) and 11PP0001 is pop (10 states). `pair_sel` is PP, except that PP=3 gives `pair_sel`=4, the status-word pair.
- R10: Every opcode not covered by R2 to R9 is class idle. It takes 4 states, with `imm_bytes`=0, `mem_ref`=0 and all select outputs at 0.
- R11: Select outputs that a class does not use read 0. `alu_op` is 0 outside the two ALU classes and `pair_sel` is 0 outside the six pair classes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 8 | Opcode byte to decode |
| op_class | output | 14 | One-hot instruction class, bit positions as in R1 |
| dst_reg | output | 3 | Destination register code |
| src_reg | output | 3 | Source register code |
| pair_sel | output | 3 | Register-pair code: BC, DE, HL, SP, status-word pair |
| alu_op | output | 3 | ALU operation code |
| mem_ref | output | 1 | An 8-bit operand is memory addressed through HL |
| imm_bytes | output | 2 | Number of immediate bytes after the opcode |
| state_count | output | STATE_W (5) | Base clock-state count of the instruction |

## Verification
The block holds no state. A wrong decode therefore shows at the ports in the same cycle the opcode is applied, as a wrong class bit, select field or state count. The errors most likely to slip through are at the code-6 memory positions and at the 0x76 collision. There, a decode that picks the class correctly can still report the register timing, or report a move instead of a halt. The bench therefore covers all 256 opcodes against an independent model, so no opcode position goes unobserved.

// File: rtl/octdec_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, class kinds, pair codes and state counts for the
// octal-field opcode decoder. Assumes an 8-bit opcode split 2-3-3.
package octdec_pkg;

    localparam int OPC_W   = 8;
    localparam int GRP_W   = 2;
    localparam int FIELD_W = 3;
    localparam int PAIR_W  = 3;
    localparam int IMM_W   = 2;
    localparam int CLASS_N = 14;

    // Register code that stands for the memory operand addressed by HL.
    localparam logic [FIELD_W-1:0] REG_MEM = 3'd6;

    // Register-pair select codes.
    localparam logic [PAIR_W-1:0] PR_BC  = 3'd0;
    localparam logic [PAIR_W-1:0] PR_PSW = 3'd4;

    // Base state counts.
    localparam int ST_FOUR   = 4;
    localparam int ST_FIVE   = 5;
    localparam int ST_SEVEN  = 7;
    localparam int ST_TEN    = 10;
    localparam int ST_ELEVEN = 11;

    // Instruction kinds; the value is the bit index in the one-hot class.
    typedef enum logic [3:0] {
        K_IDLE   = 4'd0,
        K_MOVE   = 4'd1,
        K_LDIMM  = 4'd2,
        K_INC    = 4'd3,
        K_DEC    = 4'd4,
        K_ALUREG = 4'd5,
        K_ALUIMM = 4'd6,
        K_WLOAD  = 4'd7,
        K_WADD   = 4'd8,
        K_WINC   = 4'd9,
        K_WDEC   = 4'd10,
        K_PUSH   = 4'd11,
        K_POP    = 4'd12,
        K_HALT   = 4'd13
    } kind_e;

    // Octal fields of one opcode.
    typedef struct packed {
        logic [GRP_W-1:0]   grp;
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } fields_t;

endpackage

// File: rtl/octdec_fields.sv
`timescale 1ns/1ps
// octdec_fields: splits the opcode into group, upper and lower octal fields.
// Assumes the 2-3-3 layout fixed by the package widths.
module octdec_fields
    import octdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output fields_t          flds
);

    // Purpose: map opcode bits onto the field struct.
    always_comb begin
        flds.grp = opcode[OPC_W-1 -: GRP_W];
        flds.hi  = opcode[2*FIELD_W-1 -: FIELD_W];
        flds.lo  = opcode[FIELD_W-1:0];
    end

endmodule

// File: rtl/octdec_class.sv
`timescale 1ns/1ps
// octdec_class: picks the instruction kind from the octal fields, expands it
// to a one-hot class vector and flags memory operands (register code 6).
// Assumes the memory-to-memory move position is halt.
module octdec_class
    import octdec_pkg::*;
(
    input  fields_t              flds,
    output kind_e                kind,
    output logic [CLASS_N-1:0]   op_class,
    output logic                 mem_ref
);

    logic hi_mem;
    logic lo_mem;

    assign hi_mem = (flds.hi == REG_MEM);
    assign lo_mem = (flds.lo == REG_MEM);

    // Purpose: select the kind by group, then by lower field.
    always_comb begin
        kind = K_IDLE;
        case (flds.grp)
            2'b00: begin
                case (flds.lo)
                    3'd1:    kind = flds.hi[0] ? K_WADD : K_WLOAD;
                    3'd3:    kind = flds.hi[0] ? K_WDEC : K_WINC;
                    3'd4:    kind = K_INC;
                    3'd5:    kind = K_DEC;
                    3'd6:    kind = K_LDIMM;
                    default: kind = K_IDLE;
                endcase
            end
            2'b01:   kind = (hi_mem && lo_mem) ? K_HALT : K_MOVE;
            2'b10:   kind = K_ALUREG;
            default: begin
                if (flds.lo == 3'd6)
                    kind = K_ALUIMM;
                else if (flds.lo == 3'd5 && !flds.hi[0])
                    kind = K_PUSH;
                else if (flds.lo == 3'd1 && !flds.hi[0])
                    kind = K_POP;
                else
                    kind = K_IDLE;
            end
        endcase
    end

    // Purpose: expand the kind into one class bit per kind.
    for (genvar k = 0; k < CLASS_N; k++) begin : g_onehot
        assign op_class[k] = (kind == kind_e'(k));
    end

    // Purpose: flag a memory operand in the slot the kind actually uses.
    always_comb begin
        case (kind)
            K_MOVE:                 mem_ref = hi_mem | lo_mem;
            K_LDIMM, K_INC, K_DEC:  mem_ref = hi_mem;
            K_ALUREG:               mem_ref = lo_mem;
            default:                mem_ref = 1'b0;
        endcase
    end

endmodule

// File: rtl/octdec_operands.sv
`timescale 1ns/1ps
// octdec_operands: routes the octal fields onto register, pair and ALU selects.
// Fields a kind does not use are driven to zero. Push and pop replace the
// stack-pointer pair code with the status-word pair code.
module octdec_operands
    import octdec_pkg::*;
(
    input  fields_t              flds,
    input  kind_e                kind,
    output logic [FIELD_W-1:0]   dst_reg,
    output logic [FIELD_W-1:0]   src_reg,
    output logic [PAIR_W-1:0]    pair_sel,
    output logic [FIELD_W-1:0]   alu_op
);

    logic [PAIR_W-1:0] pair_raw;

    assign pair_raw = {1'b0, flds.hi[2:1]};

    // Purpose: drive each select only for the kinds that consume it.
    always_comb begin
        dst_reg  = '0;
        src_reg  = '0;
        pair_sel = PR_BC;
        alu_op   = '0;
        case (kind)
            K_MOVE: begin
                dst_reg = flds.hi;
                src_reg = flds.lo;
            end
            K_LDIMM, K_INC, K_DEC: dst_reg = flds.hi;
            K_ALUREG: begin
                src_reg = flds.lo;
                alu_op  = flds.hi;
            end
            K_ALUIMM:                         alu_op = flds.hi;
            K_WLOAD, K_WADD, K_WINC, K_WDEC:  pair_sel = pair_raw;
            K_PUSH, K_POP:
                pair_sel = (flds.hi[2:1] == 2'b11) ? PR_PSW : pair_raw;
            default: ;
        endcase
    end

endmodule

// File: rtl/octdec_timing.sv
`timescale 1ns/1ps
// octdec_timing: base clock-state count and immediate byte count per kind.
// A memory operand lengthens the register form of the instruction.
module octdec_timing
    import octdec_pkg::*;
#(
    parameter int unsigned STATE_W = 5
) (
    input  kind_e               kind,
    input  logic                mem_ref,
    output logic [STATE_W-1:0]  state_count,
    output logic [IMM_W-1:0]    imm_bytes
);

    int n_states;

    // Purpose: look up the state count for the kind and memory flag.
    always_comb begin
        case (kind)
            K_MOVE:          n_states = mem_ref ? ST_SEVEN : ST_FIVE;
            K_HALT:          n_states = ST_SEVEN;
            K_LDIMM:         n_states = mem_ref ? ST_TEN : ST_SEVEN;
            K_INC, K_DEC:    n_states = mem_ref ? ST_TEN : ST_FIVE;
            K_ALUREG:        n_states = mem_ref ? ST_SEVEN : ST_FOUR;
            K_ALUIMM:        n_states = ST_SEVEN;
            K_WLOAD, K_WADD: n_states = ST_TEN;
            K_WINC, K_WDEC:  n_states = ST_FIVE;
            K_PUSH:          n_states = ST_ELEVEN;
            K_POP:           n_states = ST_TEN;
            default:         n_states = ST_FOUR;
        endcase
    end

    assign state_count = STATE_W'(n_states);

    // Purpose: report how many operand bytes follow the opcode.
    always_comb begin
        case (kind)
            K_LDIMM, K_ALUIMM: imm_bytes = 2'd1;
            K_WLOAD:           imm_bytes = 2'd2;
            default:           imm_bytes = 2'd0;
        endcase
    end

endmodule

// File: rtl/octal_opcode_decoder.sv
`timescale 1ns/1ps
// octal_opcode_decoder: combinational decode of one opcode into a one-hot
// class, register/pair/ALU selects, memory flag, immediate count and base
// state count. Assumes the opcode is held stable by the fetch logic.
module octal_opcode_decoder
    import octdec_pkg::*;
#(
    parameter int unsigned STATE_W = 5
) (
    input  logic [7:0]          opcode,
    output logic [13:0]         op_class,
    output logic [2:0]          dst_reg,
    output logic [2:0]          src_reg,
    output logic [2:0]          pair_sel,
    output logic [2:0]          alu_op,
    output logic                mem_ref,
    output logic [1:0]          imm_bytes,
    output logic [STATE_W-1:0]  state_count
);

    fields_t flds;
    kind_e   kind;

    // Purpose: field split.
    octdec_fields u_fields (
        .opcode (opcode),
        .flds   (flds)
    );

    // Purpose: class selection and memory flag.
    octdec_class u_class (
        .flds     (flds),
        .kind     (kind),
        .op_class (op_class),
        .mem_ref  (mem_ref)
    );

    // Purpose: operand select routing.
    octdec_operands u_operands (
        .flds     (flds),
        .kind     (kind),
        .dst_reg  (dst_reg),
        .src_reg  (src_reg),
        .pair_sel (pair_sel),
        .alu_op   (alu_op)
    );

    // Purpose: state and immediate counts.
    octdec_timing #(.STATE_W(STATE_W)) u_timing (
        .kind        (kind),
        .mem_ref     (mem_ref),
        .state_count (state_count),
        .imm_bytes   (imm_bytes)
    );

endmodule

// File: rtl/octal_opcode_decoder_chk.sv
`timescale 1ns/1ps
// octal_opcode_decoder_chk: immediate assertions over the decoder ports,
// bound into every instance. The block is combinational, so each property is
// checked whenever its inputs change.
module octal_opcode_decoder_chk #(
    parameter int unsigned STATE_W = 5
) (
    input logic [7:0]          opcode,
    input logic [13:0]         op_class,
    input logic [2:0]          dst_reg,
    input logic [2:0]          src_reg,
    input logic [2:0]          pair_sel,
    input logic [2:0]          alu_op,
    input logic                mem_ref,
    input logic [1:0]          imm_bytes,
    input logic [STATE_W-1:0]  state_count
);

    // Purpose: port-level consistency checks between independent outputs.
    always_comb begin
        a_r1_class_onehot: assert ($countones(op_class) == 1)
            else $error("class vector not one-hot: %b", op_class);
        if (opcode == 8'h76) begin
            a_r3_halt_decode: assert (op_class[13] && state_count == STATE_W'(7) &&
                                      !mem_ref && dst_reg == 3'd0 && src_reg == 3'd0)
                else $error("halt position decoded wrongly");
        end
        if (mem_ref) begin
            a_r2_mem_slows: assert (state_count >= STATE_W'(7))
                else $error("memory operand with short state count");
        end
        if (imm_bytes != 2'd0) begin
            a_r7_imm_class: assert (op_class[2] || op_class[6] || op_class[7])
                else $error("immediate bytes on non-immediate class");
        end
        if (pair_sel == 3'd4) begin
            a_r9_psw_stack_only: assert (op_class[11] || op_class[12])
                else $error("status-word pair outside push/pop");
        end
        if (op_class[0]) begin
            a_r10_idle_quiet: assert (state_count == STATE_W'(4) && imm_bytes == 2'd0 &&
                                      !mem_ref && pair_sel == 3'd0)
                else $error("idle class not quiet");
        end
        if (!(op_class[5] || op_class[6])) begin
            a_r11_alu_zero: assert (alu_op == 3'd0)
                else $error("alu_op nonzero outside ALU classes");
        end
    end

endmodule

bind octal_opcode_decoder octal_opcode_decoder_chk #(.STATE_W(STATE_W)) u_chk (
    .opcode      (opcode),
    .op_class    (op_class),
    .dst_reg     (dst_reg),
    .src_reg     (src_reg),
    .pair_sel    (pair_sel),
    .alu_op      (alu_op),
    .mem_ref     (mem_ref),
    .imm_bytes   (imm_bytes),
    .state_count (state_count)
);

// File: tb/octal_opcode_decoder_bench.sv
`timescale 1ns/1ps
// Bench: directed corner opcodes, a full sweep and seeded random opcodes,
// each compared with a reference model written from the requirements.
module octal_opcode_decoder_bench;

    localparam int SW = 5;

    typedef struct packed {
        logic [13:0]   cls;
        logic [2:0]    dst;
        logic [2:0]    src;
        logic [2:0]    pair;
        logic [2:0]    alu;
        logic          mem;
        logic [1:0]    imm;
        logic [SW-1:0] st;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0]    opcode = 8'h00;
    logic [13:0]   op_class;
    logic [2:0]    dst_reg, src_reg, pair_sel, alu_op;
    logic          mem_ref;
    logic [1:0]    imm_bytes;
    logic [SW-1:0] state_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    octal_opcode_decoder #(.STATE_W(SW)) u_octal_opcode_decoder (
        .opcode      (opcode),
        .op_class    (op_class),
        .dst_reg     (dst_reg),
        .src_reg     (src_reg),
        .pair_sel    (pair_sel),
        .alu_op      (alu_op),
        .mem_ref     (mem_ref),
        .imm_bytes   (imm_bytes),
        .state_count (state_count)
    );

    // Reference model built from R2..R10 by opcode bit pattern.
    function automatic exp_t model(input logic [7:0] op, output string tag);
        exp_t e = '0;
        logic [2:0] d = op[5:3];
        logic [2:0] s = op[2:0];
        logic [1:0] pp = op[5:4];
        tag = "R10";
        e.st = SW'(4);
        e.cls = 14'd1;
        casez (op)
            8'b01110110: begin
                tag = "R3"; e.cls = 14'd1 << 13; e.st = SW'(7);
            end
            8'b01??????: begin
                tag = "R2"; e.cls = 14'd1 << 1; e.dst = d; e.src = s;
                e.mem = (d == 3'd6) || (s == 3'd6);
                e.st = e.mem ? SW'(7) : SW'(5);
            end
            8'b10??????: begin
                tag = "R6"; e.cls = 14'd1 << 5; e.src = s; e.alu = d;
                e.mem = (s == 3'd6); e.st = e.mem ? SW'(7) : SW'(4);
            end
            8'b11???110: begin
                tag = "R7"; e.cls = 14'd1 << 6; e.alu = d; e.imm = 2'd1; e.st = SW'(7);
            end
            8'b11??0101: begin
                tag = "R9"; e.cls = 14'd1 << 11; e.st = SW'(11);
                e.pair = (pp == 2'd3) ? 3'd4 : {1'b0, pp};
            end
            8'b11??0001: begin
                tag = "R9"; e.cls = 14'd1 << 12; e.st = SW'(10);
                e.pair = (pp == 2'd3) ? 3'd4 : {1'b0, pp};
            end
            8'b00??0001: begin
                tag = "R8"; e.cls = 14'd1 << 7; e.pair = {1'b0, pp}; e.imm = 2'd2; e.st = SW'(10);
            end
            8'b00??1001: begin
                tag = "R8"; e.cls = 14'd1 << 8; e.pair = {1'b0, pp}; e.st = SW'(10);
            end
            8'b00??0011: begin
                tag = "R8"; e.cls = 14'd1 << 9; e.pair = {1'b0, pp}; e.st = SW'(5);
            end
            8'b00??1011: begin
                tag = "R8"; e.cls = 14'd1 << 10; e.pair = {1'b0, pp}; e.st = SW'(5);
            end
            8'b00???100, 8'b00???101: begin
                tag = "R5"; e.cls = op[0] ? (14'd1 << 4) : (14'd1 << 3); e.dst = d;
                e.mem = (d == 3'd6); e.st = e.mem ? SW'(10) : SW'(5);
            end
            8'b00???110: begin
                tag = "R4"; e.cls = 14'd1 << 2; e.dst = d; e.imm = 2'd1;
                e.mem = (d == 3'd6); e.st = e.mem ? SW'(10) : SW'(7);
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] op,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s op=%02h actual=%0h expected=%0h", tag, op, act, exp);
        end
    endtask

    // Drive one opcode after the falling edge and sample before the rising edge.
    task automatic apply(input logic [7:0] op);
        exp_t  e;
        exp_t  got;
        string tag;
        @(negedge clk);
        opcode = op;
        #1;
        e = model(op, tag);
        got = {op_class, dst_reg, src_reg, pair_sel, alu_op, mem_ref, imm_bytes, state_count};
        check(got === e, tag, op, 64'(got), 64'(e));
        check($countones(op_class) == 1, "R1", op, 64'(op_class), 64'(e.cls));
        if (!(e.cls[5] || e.cls[6]))
            check(alu_op == 3'd0, "R11 alu", op, 64'(alu_op), 64'd0);
        if (e.cls[13:7] == 7'd0 || e.cls[13])
            check(pair_sel == 3'd0, "R11 pair", op, 64'(pair_sel), 64'd0);
    endtask

    initial begin : stim
        logic [7:0] directed [22];
        directed = '{8'h00, 8'h76, 8'h40, 8'h7F, 8'h46, 8'h70, 8'h36, 8'h3E,
                     8'h34, 8'h3D, 8'h86, 8'hBF, 8'hFE, 8'h31, 8'h39, 8'hF5,
                     8'hF1, 8'hC5, 8'h03, 8'h0B, 8'hC3, 8'hFF};
        void'($urandom(32'h0C7A1));
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        // R10: opcode held at zero from start decodes as the idle class.
        apply(8'h00);
        foreach (directed[i]) apply(directed[i]);
        for (int op = 0; op < 256; op++) apply(8'(op));
        for (int i = 0; i < 400; i++) apply(8'($urandom));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule